// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that runs in the slow clock domain and is programmed through a small word-wide register port. A down-counter is reloaded whenever software restarts it. If software fails to restart it in time, the counter passes zero and the block raises a fault. Software can also restart it too early, while the count is still above a programmable window value. That is also a fault. Each fault sets a sticky status flag. It can also drive a reset request, an interrupt, or both.

The counter decrements once per `tick` pulse, which is nominally 256 per second. Software that wants a timeout of N seconds programs a reload of N*256-1, or 0 when N is 0. Register writes are locked out for a short interval after every restart. While the block is disabled, its timing fields cannot be changed. Optional halt bits freeze the count while the idle or debug inputs are high.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset, the mode register (address 1) reads 0x04FFFFFF: reload and window both 4095 and the disable bit set. The status register (address 2) reads 0xFFF00000, and `irq` and `rst_req` are low.
- R2: A write to address 0 restarts the counter only when bits 31:24 equal 0xA5 and bit 0 is 1. A write with any other key, or with bit 0 clear, leaves the counter unchanged.
- R3: Every accepted write to the mode register restarts the counter from the reload value just written.
- R4: After any restart, control and mode writes in the next 3 clock cycles are dropped. A write in the 4th cycle is accepted.
- R5: While the disable bit (mode bit 26) is set, the counter holds its value and writes leave the reload (bits 11:0) and window (bits 23:12) fields unchanged. The other mode bits still update.
- R6: The counter decrements by one on each `tick` while it runs. A `tick` that finds it at 0 sets the underflow flag and reloads it. The flag therefore appears reload+1 ticks after a restart.
- R7: A keyed restart that finds the counter above the window value sets the window-error flag and raises a fault. A restart with the counter at or below the window value sets no flag.
- R8: Each fault raises `rst_req` for one cycle when reset-enable (mode bit 24) is set. `irq` is high while interrupt-enable (mode bit 25) is set and either flag is set. Reading the status register clears both flags.
- R9: With idle-halt (mode bit 27) set and `idle` high, the counter holds. With debug-halt (mode bit 28) set and `dbg` high, it also holds. A halt input has no effect when its halt bit is clear.
- R10: The status word holds the underflow flag in bit 0, the window-error flag in bit 1 and the counter in bits 31:20. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable pulse |
| idle | input | 1 | System idle indication |
| dbg | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 control, 1 mode, 2 status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rst_req | output | 1 | Reset request |
| irq | output | 1 | Fault interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a write that lands inside the lock-out interval. The bench places a mode write 1, 2, 3 and 4 cycles after a keyed restart, then reads the mode register back. The second is the window boundary. Exact tick counts stop the counter one above the window value and again exactly at it before a keyed restart. A sweep over all seventeen whole-second reloads lines the counter up on zero, then checks that the very next tick raises the fault.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_MODE = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } wwdt_addr_e;

   // mode flag bits, rst_en is the lowest bit of the group
   typedef struct packed {
      logic dbg_halt;
      logic idle_halt;
      logic dis;
      logic irq_en;
      logic rst_en;
   } wwdt_flags_t;

   localparam int FLAG_W = 5;
   localparam int KEY_W = 8;
   localparam logic [KEY_W-1:0] DEF_KEY = 8'hA5;

endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
   import wwdt_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int DATA_W = 32,
   parameter logic [KEY_W-1:0] KEY = DEF_KEY,
   parameter int BLOCK_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              restart,
   output logic              ctrl_restart,
   output logic [CNT_W-1:0]  reload_src,
   output logic [CNT_W-1:0]  reload_q,
   output logic [CNT_W-1:0]  win_q,
   output wwdt_flags_t       flags_q
);

   localparam int BW = $clog2(BLOCK_CYC + 1);

   logic [BW-1:0]    blk_q;
   logic             wr_ok;
   logic             mode_hit;
   logic [CNT_W-1:0] wr_reload, wr_win, nxt_reload, nxt_win;
   wwdt_flags_t      wr_flags;

   assign wr_ok        = wr_en && (blk_q == '0);
   assign ctrl_restart = wr_ok && (wwdt_addr_e'(addr) == REG_CTRL) &&
                         (wdata[DATA_W-1 -: KEY_W] == KEY) && wdata[0];
   assign mode_hit     = wr_ok && (wwdt_addr_e'(addr) == REG_MODE);
   assign restart      = ctrl_restart || mode_hit;

   assign wr_reload = wdata[CNT_W-1:0];
   assign wr_win    = wdata[2*CNT_W-1:CNT_W];
   assign wr_flags  = wdata[2*CNT_W +: FLAG_W];

   // timing fields are frozen while the current disable bit is set
   assign nxt_reload = flags_q.dis ? reload_q : wr_reload;
   assign nxt_win    = flags_q.dis ? win_q    : wr_win;
   assign reload_src = mode_hit ? nxt_reload : reload_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         win_q    <= '1;
         flags_q  <= '{dbg_halt: 1'b0, idle_halt: 1'b0, dis: 1'b1,
                       irq_en: 1'b0, rst_en: 1'b0};
      end else if (mode_hit) begin
         reload_q <= nxt_reload;
         win_q    <= nxt_win;
         flags_q  <= wr_flags;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         blk_q <= '0;
      else if (restart)
         blk_q <= BW'(BLOCK_CYC);
      else if (blk_q != '0)
         blk_q <= blk_q - BW'(1);
   end

   a_r4_locked_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_q != '0) |=> $stable({flags_q, win_q, reload_q}));
   a_r4_lock_start: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (blk_q == BW'(BLOCK_CYC)));
   a_r5_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.dis |=> $stable({win_q, reload_q}));

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             idle,
   input  logic             dbg,
   input  logic             dis,
   input  logic             idle_halt,
   input  logic             dbg_halt,
   input  logic             restart,
   input  logic             ctrl_restart,
   input  logic [CNT_W-1:0] reload_src,
   input  logic [CNT_W-1:0] reload_q,
   input  logic [CNT_W-1:0] win_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             uf_evt,
   output logic             err_evt
);

   logic run;

   assign run     = tick && !dis && !(idle && idle_halt) && !(dbg && dbg_halt);
   assign uf_evt  = run && !restart && (cnt_q == '0);
   assign err_evt = ctrl_restart && !dis && (cnt_q > win_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '1;
      else if (restart)
         cnt_q <= reload_src;
      else if (run)
         cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - CNT_W'(1);
   end

   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dis && !restart) |=> $stable(cnt_q));
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && idle_halt && !restart) |=> $stable(cnt_q));
   a_r9_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg && dbg_halt && !restart) |=> $stable(cnt_q));
   a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == $past(reload_src)));

endmodule

// File: rtl/wwdt_fault.sv
module wwdt_fault #(
   parameter bit RST_STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uf_evt,
   input  logic err_evt,
   input  logic clr,
   input  logic rst_en,
   input  logic irq_en,
   output logic uf_q,
   output logic err_q,
   output logic irq,
   output logic rst_req
);

   logic fault;

   assign fault = uf_evt || err_evt;
   assign irq   = irq_en && (uf_q || err_q);

   // a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         uf_q  <= uf_evt  || (uf_q  && !clr);
         err_q <= err_evt || (err_q && !clr);
      end
   end

   generate
      if (RST_STICKY) begin : g_rst_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_req <= 1'b0;
            else        rst_req <= rst_req || (fault && rst_en);
         end
      end else begin : g_rst_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_req <= 1'b0;
            else        rst_req <= fault && rst_en;
         end
         a_r8_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
            rst_req |-> $past(fault && rst_en));
      end
   endgenerate

   a_r8_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> (uf_q || err_q));
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fault) |=> (!uf_q && !err_q));
   a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> err_q);

endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog
   import wwdt_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int DATA_W = 32,
   parameter logic [KEY_W-1:0] KEY = DEF_KEY,
   parameter int BLOCK_CYC = 3,
   parameter bit RST_STICKY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              idle,
   input  logic              dbg,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rst_req,
   output logic              irq
);

   localparam int MODE_PAD = DATA_W - 2*CNT_W - FLAG_W;
   localparam int STAT_PAD = DATA_W - CNT_W - 2;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W too small");
      end
      if (MODE_PAD < 1 || DATA_W < KEY_W + 1) begin : g_bad_data
         $error("DATA_W cannot hold the mode or control layout");
      end
      if (BLOCK_CYC < 1) begin : g_bad_block
         $error("BLOCK_CYC must be at least 1");
      end
   endgenerate

   logic             restart, ctrl_restart;
   logic [CNT_W-1:0] reload_src, reload_q, win_q, cnt_q;
   wwdt_flags_t      flags_q;
   logic             uf_evt, err_evt, uf_q, err_q, stat_clr;

   wwdt_regs #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .KEY(KEY), .BLOCK_CYC(BLOCK_CYC)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .restart(restart), .ctrl_restart(ctrl_restart), .reload_src(reload_src),
      .reload_q(reload_q), .win_q(win_q), .flags_q(flags_q)
   );

   wwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .idle(idle), .dbg(dbg),
      .dis(flags_q.dis), .idle_halt(flags_q.idle_halt),
      .dbg_halt(flags_q.dbg_halt), .restart(restart),
      .ctrl_restart(ctrl_restart), .reload_src(reload_src),
      .reload_q(reload_q), .win_q(win_q), .cnt_q(cnt_q),
      .uf_evt(uf_evt), .err_evt(err_evt)
   );

   assign stat_clr = rd_en && (wwdt_addr_e'(addr) == REG_STAT);

   wwdt_fault #(.RST_STICKY(RST_STICKY)) u_fault (
      .clk(clk), .rst_n(rst_n), .uf_evt(uf_evt), .err_evt(err_evt),
      .clr(stat_clr), .rst_en(flags_q.rst_en), .irq_en(flags_q.irq_en),
      .uf_q(uf_q), .err_q(err_q), .irq(irq), .rst_req(rst_req)
   );

   always_comb begin
      case (wwdt_addr_e'(addr))
         REG_MODE: rdata = {{MODE_PAD{1'b0}}, flags_q, win_q, reload_q};
         REG_STAT: rdata = {cnt_q, {STAT_PAD{1'b0}}, err_q, uf_q};
         default:  rdata = '0;
      endcase
   end

   a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flags_q.irq_en);

endmodule

// File: tb/tb_windowed_watchdog.sv
module tb_windowed_watchdog;
   localparam logic [7:0] KEY = 8'hA5;

   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, idle = 1'b0, dbg = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        rst_req, irq;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;
   logic [31:0] v;

   windowed_watchdog dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .idle(idle), .dbg(dbg),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rst_req(rst_req), .irq(irq)
   );

   always #10 clk = ~clk;

   function automatic logic [31:0] mode_w(int rl, int wn, bit re, bit ie,
                                          bit ds, bit ih, bit dh);
      return {3'b000, dh, ih, ds, ie, re, 12'(wn), 12'(rl)};
   endfunction

   function automatic logic [31:0] stat_w(int c, bit err, bit uf);
      return {12'(c), 18'd0, err, uf};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic ticks(int k);
      if (k > 0) begin
         @(negedge clk); tick = 1'b1;
         repeat (k) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic kick();
      wr(2'd0, {KEY, 23'd0, 1'b1});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd1, v); check("R1 mode", v, 32'h04FF_FFFF);
      rd(2'd2, v); check("R1 status", v, 32'hFFF0_0000);
      check("R1 irq", {31'd0, irq}, 32'd0);
      check("R1 rst_req", {31'd0, rst_req}, 32'd0);

      // R5 disabled counter holds, fields locked
      ticks(100);
      rd(2'd2, v); check("R5 hold", v, stat_w(4095, 0, 0));
      wr(2'd1, mode_w(100, 50, 0, 1, 1, 0, 0)); settle();
      rd(2'd1, v); check("R5 lock", v, mode_w(4095, 4095, 0, 1, 1, 0, 0));
      wr(2'd1, mode_w(300, 4095, 0, 1, 0, 0, 0)); settle();
      rd(2'd1, v); check("R5 lock on enable", v, mode_w(4095, 4095, 0, 1, 0, 0, 0));

      // R3 mode write restarts from new reload
      wr(2'd1, mode_w(300, 4095, 0, 1, 0, 0, 0)); settle();
      rd(2'd2, v); check("R3 reload", v, stat_w(300, 0, 0));
      ticks(40);
      rd(2'd2, v); check("R6 count", v, stat_w(260, 0, 0));
      wr(2'd1, mode_w(300, 4095, 0, 1, 0, 0, 0)); settle();
      rd(2'd2, v); check("R3 rewrite", v, stat_w(300, 0, 0));

      // R2 keyed restart
      ticks(50);
      wr(2'd0, {8'h5A, 23'd0, 1'b1}); settle();
      rd(2'd2, v); check("R2 wrong key", v, stat_w(250, 0, 0));
      wr(2'd0, {KEY, 24'd0}); settle();
      rd(2'd2, v); check("R2 no restart bit", v, stat_w(250, 0, 0));
      kick(); settle();
      rd(2'd2, v); check("R2 good key", v, stat_w(300, 0, 0));

      // R4 lock-out after restart
      for (int d = 1; d <= 4; d++) begin
         @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = {KEY, 23'd0, 1'b1};
         for (int i = 1; i < d; i++) begin
            @(negedge clk); wr_en = 1'b0;
         end
         @(negedge clk); wr_en = 1'b1; addr = 2'd1;
         wdata = mode_w(500 + d, 4095, 0, 1, 0, 0, 0);
         @(negedge clk); wr_en = 1'b0;
         settle();
         rd(2'd1, v);
         check($sformatf("R4 offset %0d", d), v,
               mode_w((d < 4) ? 300 : 504, 4095, 0, 1, 0, 0, 0));
      end

      // R7 window error at and around the boundary
      wr(2'd1, mode_w(1000, 500, 1, 1, 0, 0, 0)); settle();
      rd(2'd2, v); check("R7 setup", v, stat_w(1000, 0, 0));
      kick();
      check("R8 rst pulse on window fault", {31'd0, rst_req}, 32'd1);
      check("R7 irq on window fault", {31'd0, irq}, 32'd1);
      @(negedge clk);
      check("R8 rst one cycle", {31'd0, rst_req}, 32'd0);
      settle();
      rd(2'd2, v); check("R7 err flag R10", v, stat_w(1000, 1, 0));
      check("R8 irq cleared by read", {31'd0, irq}, 32'd0);
      ticks(499); kick(); settle();
      rd(2'd2, v); check("R7 one above window", v, stat_w(1000, 1, 0));
      ticks(500); kick(); settle();
      rd(2'd2, v); check("R7 at window", v, stat_w(1000, 0, 0));
      check("R7 no irq at window", {31'd0, irq}, 32'd0);

      // R6 R8 underflow sweep over whole-second reloads
      for (int n = 0; n <= 16; n++) begin
         int rl;
         rl = (n == 0) ? 0 : n * 256 - 1;
         wr(2'd1, mode_w(rl, 4095, 1, 1, 0, 0, 0)); settle();
         rd(2'd2, v);
         ticks(rl);
         rd(2'd2, v); check($sformatf("R6 at zero n=%0d", n), v, stat_w(0, 0, 0));
         check("R6 no early irq", {31'd0, irq}, 32'd0);
         ticks(1);
         check($sformatf("R8 irq n=%0d", n), {31'd0, irq}, 32'd1);
         check($sformatf("R8 rst n=%0d", n), {31'd0, rst_req}, 32'd1);
         rd(2'd2, v); check($sformatf("R6 underflow n=%0d", n), v, stat_w(rl, 0, 1));
         check("R8 irq clear", {31'd0, irq}, 32'd0);
      end

      // R9 halts
      wr(2'd1, mode_w(1000, 4095, 0, 0, 0, 1, 0)); settle();
      idle = 1'b1; ticks(30);
      rd(2'd2, v); check("R9 idle halt", v, stat_w(1000, 0, 0));
      idle = 1'b0; ticks(30);
      rd(2'd2, v); check("R9 idle released", v, stat_w(970, 0, 0));
      dbg = 1'b1; ticks(10);
      rd(2'd2, v); check("R9 dbg ignored", v, stat_w(960, 0, 0));
      wr(2'd1, mode_w(1000, 4095, 0, 0, 0, 1, 1)); settle();
      ticks(20);
      rd(2'd2, v); check("R9 dbg halt", v, stat_w(1000, 0, 0));
      dbg = 1'b0; ticks(5);
      rd(2'd2, v); check("R9 dbg released", v, stat_w(995, 0, 0));

      // R8 fault with both enables clear
      wr(2'd1, mode_w(3, 4095, 0, 0, 0, 0, 0)); settle();
      ticks(4);
      check("R8 irq masked", {31'd0, irq}, 32'd0);
      check("R8 rst masked", {31'd0, rst_req}, 32'd0);
      rd(2'd2, v); check("R8 flag still set", v, stat_w(3, 0, 1));

      finish_run();
   end
endmodule